// File: doc/BRIEF.md
# Configuration Access Lock Controller

This block stands between a maintenance command source and an on-chip configuration store. Each command arrives on a valid/ready port with a 3-bit opcode, an address, a write word and a key word. Maintenance commands (read, write, verify, erase) are handed to the store over a request/acknowledge interface only while the device is unlocked. Every other case gets an error code and never reaches the store.

Protection has two tiers. A temporary lock is set and cleared with a designer-chosen key, which is a build parameter of 75 to 263 bits. This keeps the device reprogrammable in the field by anyone who holds the key. A permanent lock is one-way. Once it is set, no command reaches the store, every lock opcode is refused even with the correct key, and the debug/programming port enable is withdrawn. Both lock bits stand in for nonvolatile cells: they take a power-up value from parameters and are not touched by the reset input. A saturating counter reports how many key attempts have failed.

Top module: `cfg_lock_ctrl`

## Requirements
- R1: After reset deasserts, `cmd_ready`=1, `rsp_valid`=0, `store_req`=0, `fail_count`=0, and with the default power-up values `lock_temp`=0 and `lock_perm`=0.
- R2: While neither lock is set, READ(0), WRITE(1), VERIFY(2) and ERASE(3) raise `store_req` with `store_op`=opcode[1:0] and the command's address and write word. The request is held steady until `store_ack`. In the cycle after the acknowledge edge the response carries code OK(0). `rsp_rdata` is `store_rdata` for READ and VERIFY and 0 for WRITE and ERASE.
- R3: While either lock bit is set, all four maintenance opcodes answer LOCKED(1) and `store_req` stays low.
- R4: LOCK(4) with the correct key sets `lock_temp` and answers OK. UNLOCK(5) with the correct key clears it and answers OK.
- R5: A LOCK or UNLOCK with a wrong key, or a PERMLOCK with a wrong key while `lock_temp`=1, answers BADKEY(2) and leaves both lock bits unchanged. It also raises `fail_count` by one, and the count saturates at its maximum (7 by default).
- R6: The key is compared over its full width. A key that differs only in its most or least significant bit is a wrong key.
- R7: PERMLOCK(6) sets `lock_perm` and answers OK when `lock_temp`=0 (with any key) or when the correct key is given.
- R8: Once `lock_perm`=1, it stays set. LOCK, UNLOCK and PERMLOCK answer PERMANENT(3) even with the correct key and change no lock bit.
- R9: `dbg_port_en` is 1 exactly while `lock_perm`=0.
- R10: Asserting `rst_n` changes neither `lock_temp` nor `lock_perm`. It does clear `fail_count`.
- R11: Opcode 7 answers BADOP(4) and changes no lock bit, counter or store signal.
- R12: Each accepted command gives exactly one single-cycle `rsp_valid` pulse. `cmd_ready` is low from acceptance until that pulse has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (sequencer and counter only) |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command accepted on this edge |
| cmd_op | input | 3 | Opcode |
| cmd_key | input | KEY_W | Key word for lock opcodes |
| cmd_addr | input | ADDR_W | Store address |
| cmd_wdata | input | DATA_W | Write/compare word |
| rsp_valid | output | 1 | Response pulse |
| rsp_code | output | 3 | OK=0, LOCKED=1, BADKEY=2, PERMANENT=3, BADOP=4 |
| rsp_rdata | output | DATA_W | Returned store word |
| store_req | output | 1 | Store request, held until acknowledge |
| store_op | output | 2 | Maintenance operation to the store |
| store_addr | output | ADDR_W | Store address |
| store_wdata | output | DATA_W | Store write word |
| store_ack | input | 1 | Store completed request |
| store_rdata | input | DATA_W | Store read/verify word |
| lock_temp | output | 1 | Key-reversible lock bit |
| lock_perm | output | 1 | Permanent lock bit |
| fail_count | output | FAIL_W | Saturating failed-key counter |
| dbg_port_en | output | 1 | Debug/programming port enable |

## Verification
Random command mixes are run against a bench model of the lock policy. About half use the correct key and half use a randomly corrupted key, with store acknowledge delays varied, so that forwarding is separated from refusal in each lock state. Keys wrong in only the top or bottom bit show whether the comparison covers the full width. Repeated bad attempts drive the counter into saturation. A directed permanent-lock sequence, followed by a reset, shows that a correct key no longer helps and that neither lock bit follows reset.

// File: rtl/cfg_lock_pkg.sv
// Shared opcode, response and sequencer-state encodings for the lock controller.
package cfg_lock_pkg;
    typedef enum logic [2:0] {
        OP_READ   = 3'd0,
        OP_WRITE  = 3'd1,
        OP_VERIFY = 3'd2,
        OP_ERASE  = 3'd3,
        OP_LOCK   = 3'd4,
        OP_UNLOCK = 3'd5,
        OP_PERM   = 3'd6,
        OP_RSVD   = 3'd7
    } cmd_op_e;

    typedef enum logic [2:0] {
        RSP_OK     = 3'd0,
        RSP_LOCKED = 3'd1,
        RSP_BADKEY = 3'd2,
        RSP_PERM   = 3'd3,
        RSP_BADOP  = 3'd4
    } rsp_code_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STORE = 2'd1,
        ST_RESP  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/cfg_lock_keycmp.sv
// Key comparator: checks the presented key against the built-in key.
// All slices are compared in parallel and then ANDed, so the result does not
// depend on where a mismatch sits. Assumes KEY_VALUE is the designer key.
module cfg_lock_keycmp #(
    parameter int KEY_W = 96,
    parameter logic [KEY_W-1:0] KEY_VALUE = '0
) (
    input  logic [KEY_W-1:0] key_in,
    output logic             key_ok
);
    localparam int SLICE_W = 32;
    localparam int SLICES  = (KEY_W + SLICE_W - 1) / SLICE_W;
    localparam int PAD_W   = SLICES * SLICE_W;

    logic [PAD_W-1:0]  diff;
    logic [SLICES-1:0] slice_ok;

    // Bitwise difference, zero-padded to whole slices.
    assign diff = PAD_W'(key_in ^ KEY_VALUE);

    for (genvar s = 0; s < SLICES; s++) begin : g_slice
        // One slice matches when it shows no differing bit.
        assign slice_ok[s] = (diff[s*SLICE_W +: SLICE_W] == '0);
    end

    // The key is accepted only if every slice matches.
    assign key_ok = &slice_ok;
endmodule

// File: rtl/cfg_lock_state.sv
// Lock state holder: the temporary and permanent lock bits model nonvolatile
// cells. They start from their parameter values and ignore rst_n. The
// failed-key counter is ordinary state and is cleared by reset. Assumes the
// sequencer raises at most one update pulse per cycle.
module cfg_lock_state #(
    parameter bit TEMP_INIT = 1'b0,
    parameter bit PERM_INIT = 1'b0,
    parameter int FAIL_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_temp,
    input  logic              clr_temp,
    input  logic              set_perm,
    input  logic              key_fail,
    output logic              lock_temp,
    output logic              lock_perm,
    output logic [FAIL_W-1:0] fail_count
);
    localparam logic [FAIL_W-1:0] FAIL_MAX = '1;

    logic              temp_q = TEMP_INIT;
    logic              perm_q = PERM_INIT;
    logic [FAIL_W-1:0] fail_q;

    // Lock bits: updated only by granted lock commands, never by reset.
    always_ff @(posedge clk) begin
        if (set_perm) begin
            perm_q <= 1'b1;
        end
        if (set_temp) begin
            temp_q <= 1'b1;
        end else if (clr_temp) begin
            temp_q <= 1'b0;
        end
    end

    // Failed-key counter: saturating, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail_q <= '0;
        end else if (key_fail && fail_q != FAIL_MAX) begin
            fail_q <= fail_q + 1'b1;
        end
    end

    assign lock_temp  = temp_q;
    assign lock_perm  = perm_q;
    assign fail_count = fail_q;

    // R8
    perm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        perm_q |=> perm_q);
    // R5
    fail_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_q == FAIL_MAX) |=> (fail_q == FAIL_MAX));
    // R5
    fail_keeps_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_fail |=> (temp_q == $past(temp_q) && perm_q == $past(perm_q)));
endmodule

// File: rtl/cfg_lock_seq.sv
// Command sequencer: accepts one command at a time and decides it under the
// lock policy. Allowed maintenance commands go to the store. Lock commands
// are turned into update pulses. Every accepted command gets one response.
// Assumes the store holds store_ack for one cycle per request.
module cfg_lock_seq
    import cfg_lock_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              key_ok,
    input  logic              lock_temp,
    input  logic              lock_perm,
    output logic              rsp_valid,
    output logic [2:0]        rsp_code,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              store_req,
    output logic [1:0]        store_op,
    output logic [ADDR_W-1:0] store_addr,
    output logic [DATA_W-1:0] store_wdata,
    input  logic              store_ack,
    input  logic [DATA_W-1:0] store_rdata,
    output logic              set_temp,
    output logic              clr_temp,
    output logic              set_perm,
    output logic              key_fail
);
    seq_state_e        state_q;
    cmd_op_e           op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    rsp_code_e         code_q;
    logic [DATA_W-1:0] rdata_q;

    logic      accept;
    logic      go_store;
    rsp_code_e dec_code;
    logic      dec_set_temp, dec_clr_temp, dec_set_perm, dec_fail;

    assign cmd_ready = rst_n && (state_q == ST_IDLE);
    assign accept    = cmd_valid && cmd_ready;

    // Policy decision for the command on the port.
    always_comb begin
        go_store     = 1'b0;
        dec_code     = RSP_OK;
        dec_set_temp = 1'b0;
        dec_clr_temp = 1'b0;
        dec_set_perm = 1'b0;
        dec_fail     = 1'b0;
        case (cmd_op_e'(cmd_op))
            OP_READ, OP_WRITE, OP_VERIFY, OP_ERASE: begin
                if (lock_temp || lock_perm) dec_code = RSP_LOCKED;
                else                        go_store = 1'b1;
            end
            OP_LOCK: begin
                if (lock_perm)   dec_code = RSP_PERM;
                else if (key_ok) dec_set_temp = 1'b1;
                else begin
                    dec_code = RSP_BADKEY;
                    dec_fail = 1'b1;
                end
            end
            OP_UNLOCK: begin
                if (lock_perm)   dec_code = RSP_PERM;
                else if (key_ok) dec_clr_temp = 1'b1;
                else begin
                    dec_code = RSP_BADKEY;
                    dec_fail = 1'b1;
                end
            end
            OP_PERM: begin
                if (lock_perm)                dec_code = RSP_PERM;
                else if (!lock_temp || key_ok) dec_set_perm = 1'b1;
                else begin
                    dec_code = RSP_BADKEY;
                    dec_fail = 1'b1;
                end
            end
            default: dec_code = RSP_BADOP;
        endcase
    end

    // Lock updates happen only on the accepting edge.
    assign set_temp = accept && dec_set_temp;
    assign clr_temp = accept && dec_clr_temp;
    assign set_perm = accept && dec_set_perm;
    assign key_fail = accept && dec_fail;

    // Sequencer: idle -> (store) -> response -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_READ;
            addr_q  <= '0;
            wdata_q <= '0;
            code_q  <= RSP_OK;
            rdata_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        op_q    <= cmd_op_e'(cmd_op);
                        addr_q  <= cmd_addr;
                        wdata_q <= cmd_wdata;
                        rdata_q <= '0;
                        code_q  <= dec_code;
                        state_q <= go_store ? ST_STORE : ST_RESP;
                    end
                end
                ST_STORE: begin
                    if (store_ack) begin
                        code_q  <= RSP_OK;
                        rdata_q <= (op_q == OP_READ || op_q == OP_VERIFY) ? store_rdata : '0;
                        state_q <= ST_RESP;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign store_req   = (state_q == ST_STORE);
    assign store_op    = op_q[1:0];
    assign store_addr  = addr_q;
    assign store_wdata = wdata_q;
    assign rsp_valid   = (state_q == ST_RESP);
    assign rsp_code    = code_q;
    assign rsp_rdata   = rdata_q;

    // R3
    no_store_when_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |-> !(lock_temp || lock_perm));
    // R2
    store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store_req && !store_ack) |=> (store_req && $stable(store_addr) && $stable(store_op)));
    // R12
    busy_during_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !cmd_ready);
    // R12
    single_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/cfg_lock_ctrl.sv
// Configuration access lock controller (top). Joins the key comparator, the
// lock state holder and the command sequencer. The debug/programming port
// enable is withdrawn once the permanent lock is set. Assumes KEY_W lies
// between 75 and 263 bits.
module cfg_lock_ctrl #(
    parameter int KEY_W  = 96,
    parameter logic [KEY_W-1:0] KEY_VALUE = KEY_W'(96'h3C5A_9E21_7B04_D6F8_11E2_A4C7),
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int FAIL_W = 3,
    parameter bit TEMP_INIT = 1'b0,
    parameter bit PERM_INIT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [KEY_W-1:0]  cmd_key,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              rsp_valid,
    output logic [2:0]        rsp_code,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              store_req,
    output logic [1:0]        store_op,
    output logic [ADDR_W-1:0] store_addr,
    output logic [DATA_W-1:0] store_wdata,
    input  logic              store_ack,
    input  logic [DATA_W-1:0] store_rdata,
    output logic              lock_temp,
    output logic              lock_perm,
    output logic [FAIL_W-1:0] fail_count,
    output logic              dbg_port_en
);
    logic key_ok;
    logic set_temp, clr_temp, set_perm, key_fail;

    cfg_lock_keycmp #(.KEY_W(KEY_W), .KEY_VALUE(KEY_VALUE)) u_keycmp (
        .key_in (cmd_key),
        .key_ok (key_ok)
    );

    cfg_lock_state #(.TEMP_INIT(TEMP_INIT), .PERM_INIT(PERM_INIT), .FAIL_W(FAIL_W)) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_temp   (set_temp),
        .clr_temp   (clr_temp),
        .set_perm   (set_perm),
        .key_fail   (key_fail),
        .lock_temp  (lock_temp),
        .lock_perm  (lock_perm),
        .fail_count (fail_count)
    );

    cfg_lock_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_ready   (cmd_ready),
        .cmd_op      (cmd_op),
        .cmd_addr    (cmd_addr),
        .cmd_wdata   (cmd_wdata),
        .key_ok      (key_ok),
        .lock_temp   (lock_temp),
        .lock_perm   (lock_perm),
        .rsp_valid   (rsp_valid),
        .rsp_code    (rsp_code),
        .rsp_rdata   (rsp_rdata),
        .store_req   (store_req),
        .store_op    (store_op),
        .store_addr  (store_addr),
        .store_wdata (store_wdata),
        .store_ack   (store_ack),
        .store_rdata (store_rdata),
        .set_temp    (set_temp),
        .clr_temp    (clr_temp),
        .set_perm    (set_perm),
        .key_fail    (key_fail)
    );

    // Debug/programming access exists only before the permanent lock.
    assign dbg_port_en = !lock_perm;

    // R9
    dbg_off_after_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_perm) |-> !dbg_port_en);
endmodule

// File: tb/cfg_lock_ctrl_bench.sv
// Self-checking bench: a policy model in the bench predicts every response,
// and a store model acknowledges forwarded requests after a random delay.
module cfg_lock_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int KEY_W  = 96;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int FAIL_W = 3;
    localparam int FAIL_MAX = 7;
    localparam logic [KEY_W-1:0] BENCH_KEY = 96'hC0DE_5EED_1234_ABCD_9876_F00D;

    localparam logic [2:0] C_OK = 3'd0, C_LOCKED = 3'd1, C_BADKEY = 3'd2,
                           C_PERM = 3'd3, C_BADOP = 3'd4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic [2:0]        cmd_op = '0;
    logic [KEY_W-1:0]  cmd_key = '0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [DATA_W-1:0] cmd_wdata = '0;
    logic              rsp_valid;
    logic [2:0]        rsp_code;
    logic [DATA_W-1:0] rsp_rdata;
    logic              store_req;
    logic [1:0]        store_op;
    logic [ADDR_W-1:0] store_addr;
    logic [DATA_W-1:0] store_wdata;
    logic              store_ack = 1'b0;
    logic [DATA_W-1:0] store_rdata = '0;
    logic              lock_temp, lock_perm, dbg_port_en;
    logic [FAIL_W-1:0] fail_count;

    int checks = 0;
    int failures = 0;
    bit timed_out = 0;
    int ack_wait = 0;

    bit exp_temp = 0;
    bit exp_perm = 0;
    int exp_fail = 0;

    cfg_lock_ctrl #(.KEY_W(KEY_W), .KEY_VALUE(BENCH_KEY), .ADDR_W(ADDR_W),
                    .DATA_W(DATA_W), .FAIL_W(FAIL_W)) u_cfg_lock_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_key(cmd_key), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_rdata(rsp_rdata),
        .store_req(store_req), .store_op(store_op), .store_addr(store_addr),
        .store_wdata(store_wdata), .store_ack(store_ack), .store_rdata(store_rdata),
        .lock_temp(lock_temp), .lock_perm(lock_perm), .fail_count(fail_count),
        .dbg_port_en(dbg_port_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DATA_W-1:0] store_word(input logic [ADDR_W-1:0] a);
        return {a, ~a};
    endfunction

    // Store model: acknowledges a held request for one cycle after 0..3 waits.
    always @(negedge clk) begin
        if (store_ack) begin
            store_ack = 1'b0;
        end else if (store_req) begin
            if (ack_wait == 0) begin
                store_ack   = 1'b1;
                store_rdata = store_word(store_addr);
                ack_wait    = int'($urandom % 4);
            end else begin
                ack_wait--;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Policy model: predicted code and whether the store is used.
    task automatic model(input logic [2:0] op, input bit key_good,
                         output logic [2:0] code, output bit fwd);
        fwd = 0;
        code = C_OK;
        case (op)
            3'd0, 3'd1, 3'd2, 3'd3: if (exp_temp || exp_perm) code = C_LOCKED; else fwd = 1;
            3'd4: if (exp_perm) code = C_PERM;
                  else if (key_good) exp_temp = 1;
                  else begin code = C_BADKEY; if (exp_fail < FAIL_MAX) exp_fail++; end
            3'd5: if (exp_perm) code = C_PERM;
                  else if (key_good) exp_temp = 0;
                  else begin code = C_BADKEY; if (exp_fail < FAIL_MAX) exp_fail++; end
            3'd6: if (exp_perm) code = C_PERM;
                  else if (!exp_temp || key_good) exp_perm = 1;
                  else begin code = C_BADKEY; if (exp_fail < FAIL_MAX) exp_fail++; end
            default: code = C_BADOP;
        endcase
    endtask

    // Issue one command, wait for its response, and compare with the model.
    task automatic run_cmd(input logic [2:0] op, input logic [KEY_W-1:0] key,
                           input logic [ADDR_W-1:0] addr, input logic [DATA_W-1:0] wd,
                           input string req);
        logic [2:0] ecode;
        bit efwd;
        bit fwd = 0;
        bit got = 0;
        logic [2:0] code = '0;
        logic [DATA_W-1:0] rd = '0;
        logic [DATA_W-1:0] erd;
        model(op, key == BENCH_KEY, ecode, efwd);
        @(negedge clk);
        chk(cmd_ready === 1'b1, "R12", "ready when idle", longint'(cmd_ready), 1);
        cmd_valid = 1'b1; cmd_op = op; cmd_key = key; cmd_addr = addr; cmd_wdata = wd;
        @(posedge clk);
        for (int n = 0; n < 40 && !got; n++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            if (store_req) begin
                if (!fwd) begin
                    chk(store_op == op[1:0] && store_addr == addr && store_wdata == wd,
                        "R2", "store request fields", longint'(store_addr), longint'(addr));
                end
                fwd = 1;
            end
            if (rsp_valid) begin
                got = 1; code = rsp_code; rd = rsp_rdata;
            end else begin
                chk(cmd_ready === 1'b0, "R12", "busy until response", longint'(cmd_ready), 0);
            end
        end
        chk(got, "R12", "response arrived", longint'(got), 1);
        chk(code == ecode, req, "response code", longint'(code), longint'(ecode));
        chk(fwd == efwd, efwd ? "R2" : "R3", "store forwarding", longint'(fwd), longint'(efwd));
        if (efwd) begin
            erd = (op == 3'd0 || op == 3'd2) ? store_word(addr) : '0;
            chk(rd == erd, "R2", "response data", longint'(rd), longint'(erd));
        end
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R12", "single response pulse", longint'(rsp_valid), 0);
        chk(lock_temp == exp_temp && lock_perm == exp_perm, "R5",
            "lock state after command", longint'({lock_perm, lock_temp}),
            longint'({exp_perm, exp_temp}));
        chk(int'(fail_count) == exp_fail, "R5", "fail counter",
            longint'(fail_count), longint'(exp_fail));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        exp_fail = 0;
        @(negedge clk);
    endtask

    function automatic logic [KEY_W-1:0] bad_key();
        logic [KEY_W-1:0] m;
        m = {$urandom, $urandom, $urandom};
        if (m == '0) m[0] = 1'b1;
        return BENCH_KEY ^ m;
    endfunction

    task automatic run_all();
        logic [KEY_W-1:0] msb_bad;
        logic [KEY_W-1:0] lsb_bad;
        msb_bad = BENCH_KEY ^ {1'b1, {(KEY_W-1){1'b0}}};
        lsb_bad = BENCH_KEY ^ {{(KEY_W-1){1'b0}}, 1'b1};
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cmd_ready === 1'b1 && rsp_valid === 1'b0 && store_req === 1'b0, "R1",
            "idle outputs", longint'({cmd_ready, rsp_valid, store_req}), 3'b100);
        chk(fail_count == '0 && lock_temp == 1'b0 && lock_perm == 1'b0, "R1",
            "lock state at power-up", longint'({fail_count, lock_perm, lock_temp}), 0);
        chk(dbg_port_en === 1'b1, "R9", "debug port open", longint'(dbg_port_en), 1);

        // R2 directed maintenance commands while open
        run_cmd(3'd0, '0, 16'h1234, 32'h0, "R2");
        run_cmd(3'd1, '0, 16'hFFFF, 32'hDEAD_BEEF, "R2");
        run_cmd(3'd2, '0, 16'h0001, 32'h5555_AAAA, "R2");
        run_cmd(3'd3, '0, 16'h8000, 32'h0, "R2");
        // R4 lock, then R3 refusals
        run_cmd(3'd4, BENCH_KEY, '0, '0, "R4");
        run_cmd(3'd0, BENCH_KEY, 16'h0042, '0, "R3");
        run_cmd(3'd3, BENCH_KEY, 16'h0043, '0, "R3");
        // R6 single-bit key errors at both ends
        run_cmd(3'd5, msb_bad, '0, '0, "R6");
        run_cmd(3'd5, lsb_bad, '0, '0, "R6");
        run_cmd(3'd5, BENCH_KEY, '0, '0, "R4");
        // R11 reserved opcode
        run_cmd(3'd7, BENCH_KEY, 16'h0007, 32'h7, "R11");
        // R10 reset leaves the temporary lock alone
        run_cmd(3'd4, BENCH_KEY, '0, '0, "R4");
        do_reset();
        chk(lock_temp === 1'b1, "R10", "temp lock across reset", longint'(lock_temp), 1);
        chk(fail_count == '0, "R10", "counter cleared by reset", longint'(fail_count), 0);
        run_cmd(3'd1, '0, 16'h0100, 32'h1, "R3");
        run_cmd(3'd5, BENCH_KEY, '0, '0, "R4");

        // Random mix (no permanent lock yet)
        for (int i = 0; i < 400; i++) begin
            logic [2:0] op;
            logic [KEY_W-1:0] key;
            op = 3'($urandom % 8);
            if (op == 3'd6) op = 3'd7;
            key = ($urandom % 2 == 0) ? BENCH_KEY : bad_key();
            run_cmd(op, key, 16'($urandom), $urandom,
                    (op < 3'd4) ? "R3" : (op == 3'd7 ? "R11" : "R5"));
        end

        // R5 saturation
        if (exp_temp) run_cmd(3'd5, BENCH_KEY, '0, '0, "R4");
        for (int i = 0; i < FAIL_MAX + 3; i++) run_cmd(3'd4, bad_key(), '0, '0, "R5");
        chk(int'(fail_count) == FAIL_MAX, "R5", "counter saturated",
            longint'(fail_count), longint'(FAIL_MAX));

        // R7 permanent lock rules
        run_cmd(3'd4, BENCH_KEY, '0, '0, "R4");
        run_cmd(3'd6, bad_key(), '0, '0, "R7");
        chk(lock_perm === 1'b0, "R7", "perm refused without key", longint'(lock_perm), 0);
        run_cmd(3'd6, BENCH_KEY, '0, '0, "R7");
        chk(lock_perm === 1'b1, "R7", "perm set with key", longint'(lock_perm), 1);
        chk(dbg_port_en === 1'b0, "R9", "debug port closed", longint'(dbg_port_en), 0);
        // R8 correct key no longer helps
        run_cmd(3'd5, BENCH_KEY, '0, '0, "R8");
        run_cmd(3'd4, BENCH_KEY, '0, '0, "R8");
        run_cmd(3'd6, BENCH_KEY, '0, '0, "R8");
        run_cmd(3'd0, BENCH_KEY, 16'h0010, '0, "R3");
        run_cmd(3'd2, BENCH_KEY, 16'h0011, '0, "R3");
        chk(lock_temp === 1'b1, "R8", "temp lock unchanged", longint'(lock_temp), 1);
        // R10 reset leaves the permanent lock alone
        do_reset();
        chk(lock_perm === 1'b1 && dbg_port_en === 1'b0, "R10", "perm lock across reset",
            longint'({lock_perm, dbg_port_en}), 2'b10);
        run_cmd(3'd3, BENCH_KEY, 16'h0200, '0, "R8");
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=expired expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule